// File: doc/BRIEF.md
# Serially Loaded Feedback Divider Control Register

This block supplies the 6-bit feedback divide ratio of a clock synthesizer that can shift its output frequency up or down for margin testing. A three-wire serial port fills a shift register: a level-sensitive load enable, a serial clock and a serial data line. When the load enable falls, the shift register contents are copied into a divider control register. A mode input selects what reaches the output. When the mode input is low, the output is a fixed nominal ratio of 50. When it is high, the output is the committed register value.

All three serial pins are treated as asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and its edges are found there. A range flag marks any ratio in use that lies outside the band the oscillator can lock to (45 to 55). Out-of-band values are passed through unchanged, not clamped. A small divide-by-M counter turns the ratio in use into a periodic one-cycle tick, so the ratio can be observed as a period.

Top module: `margin_divider_ctrl`

## Requirements
- R1: After reset, the committed ratio is 50 (binary 110010) and the range flag is low, whatever the mode input.
- R2: While the mode input is low, the divider word output is 50, whatever value has been committed.
- R3: While the mode input is high, the divider word output equals the committed ratio. The serial bits arrive most significant first: the first bit shifted in ends up at bit 5 and the sixth bit at bit 0.
- R4: While the synchronized load enable is low, edges on the serial clock and changes on the serial data leave the shift register unchanged. A later load pulse with no clock edges therefore commits the value shifted in earlier.
- R5: The committed ratio changes only on a high-to-low transition of the load enable. Shifting while the enable is high leaves the output unchanged.
- R6: Serial loading is accepted while the mode input is low. The committed value appears at the output once the mode input goes high.
- R7: Taking the mode input from high back to low restores 50 at the output, and the range flag goes low.
- R8: The range flag is high exactly when the divider word output is below 45 or above 55. Such values appear at the output unclamped.
- R9: When more than six serial clock edges occur within one load window, the last six bits shifted in form the committed ratio.
- R10: The feedback tick pulses once every M system clock cycles, where M is the divider word output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en_i | input | 1 | Serial load enable, asynchronous, active high |
| sclk_i | input | 1 | Serial clock, asynchronous; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, asynchronous, most significant bit first |
| margin_mode_i | input | 1 | 1 selects the committed ratio, 0 the nominal ratio |
| div_word_o | output | 6 | Feedback divide ratio in use |
| out_of_range_o | output | 1 | High when the ratio in use is outside 45..55 |
| fb_tick_o | output | 1 | One-cycle pulse every div_word_o cycles |

## Verification
A serial pin change reaches the logic on the second system clock edge after it is driven. Its edge is acted on at the third edge. A load-enable fall therefore updates the committed ratio three clock edges after the pin falls. A mode change alters the word and the flag in the same cycle, because that path has no register. The bench holds every serial level for at least three cycles and samples on the falling clock edge. It waits six cycles after each load-enable fall before reading the output, and it checks that the word is unchanged while the enable is still high. The tick period is measured between the second and third ticks after any change of ratio, so the wrap that happens during the change does not enter the result.

// File: rtl/mdiv_pkg.sv
// Package: shared constants for the feedback divider control block.
// Assumes: a 6-bit divider word and a 45..55 lockable band.
package mdiv_pkg;
    parameter int unsigned MDIV_W      = 6;
    parameter int unsigned MDIV_NOM    = 50;
    parameter int unsigned MDIV_MIN    = 45;
    parameter int unsigned MDIV_MAX    = 55;
    parameter int unsigned SYNC_DEPTH  = 2;
endpackage

// File: rtl/mdiv_sync.sv
// Module: multi-bit flop-chain synchronizer for independent asynchronous levels.
// Assumes: each bit is a slow level, so bits need no coherence with one another.
module mdiv_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage lets metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mdiv_serial_capture.sv
// Module: shift register and commit register driven by the synchronized serial port.
// Assumes: the inputs are already synchronized to clk, and the data is stable
// around each serial clock rise.
module mdiv_serial_capture #(
    parameter int unsigned W         = 6,
    parameter int unsigned RESET_VAL = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_s_i,
    input  logic         sclk_s_i,
    input  logic         sdata_s_i,
    output logic [W-1:0] shift_q_o,
    output logic [W-1:0] ctrl_q_o,
    output logic         commit_o
);
    localparam logic [W-1:0] RST_W = W'(RESET_VAL);

    logic load_d, sclk_d, shift_en;

    // Delayed copies of the synchronized levels, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_d <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            load_d <= load_s_i;
            sclk_d <= sclk_s_i;
        end
    end

    assign shift_en = load_s_i & sclk_s_i & ~sclk_d;
    assign commit_o = load_d & ~load_s_i;

    // Shift in one bit, MSB first, on each serial clock rise inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q_o <= RST_W;
        else if (shift_en) shift_q_o <= {shift_q_o[W-2:0], sdata_s_i};
    end

    // Copy the shift register into the control register on a load-enable fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q_o <= RST_W;
        else if (commit_o) ctrl_q_o <= shift_q_o;
    end
endmodule

// File: rtl/mdiv_feedback_counter.sv
// Module: divide-by-M counter that pulses once every M clock cycles.
// Assumes: M may change at any time; values 0 and 1 give a pulse every cycle.
module mdiv_feedback_counter #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] m_i,
    output logic         tick_o
);
    logic [W-1:0] cnt, term;

    assign term   = (m_i <= W'(1)) ? '0 : m_i - W'(1);
    assign tick_o = (cnt >= term);

    // Count up and wrap on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/margin_divider_ctrl.sv
// Module: top of the feedback divider control block. Synchronizes the serial
// port, captures and commits the ratio, selects the nominal or committed value,
// flags out-of-band ratios and drives the divide-by-M tick.
// Assumes: the mode input is a static strap or is already synchronous to clk.
module margin_divider_ctrl
    import mdiv_pkg::*;
#(
    parameter int unsigned W       = MDIV_W,
    parameter int unsigned NOMINAL = MDIV_NOM,
    parameter int unsigned LO      = MDIV_MIN,
    parameter int unsigned HI      = MDIV_MAX,
    parameter int unsigned STAGES  = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en_i,
    input  logic         sclk_i,
    input  logic         sdata_i,
    input  logic         margin_mode_i,
    output logic [W-1:0] div_word_o,
    output logic         out_of_range_o,
    output logic         fb_tick_o
);
    localparam logic [W-1:0] NOM_W = W'(NOMINAL);
    localparam logic [W-1:0] LO_W  = W'(LO);
    localparam logic [W-1:0] HI_W  = W'(HI);

    logic [2:0]   pins_s;
    logic         load_s, sclk_s, sdata_s, commit;
    logic [W-1:0] shift_q, ctrl_q;

    mdiv_sync #(.W(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({load_en_i, sclk_i, sdata_i}),
        .q_o   (pins_s)
    );

    assign {load_s, sclk_s, sdata_s} = pins_s;

    mdiv_serial_capture #(.W(W), .RESET_VAL(NOMINAL)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_s_i  (load_s),
        .sclk_s_i  (sclk_s),
        .sdata_s_i (sdata_s),
        .shift_q_o (shift_q),
        .ctrl_q_o  (ctrl_q),
        .commit_o  (commit)
    );

    // Mode selects the committed ratio or the fixed nominal one.
    always_comb div_word_o = margin_mode_i ? ctrl_q : NOM_W;

    // Flag ratios outside the lockable band; the value is not clamped.
    always_comb out_of_range_o = (div_word_o < LO_W) || (div_word_o > HI_W);

    mdiv_feedback_counter #(.W(W)) u_fbcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .m_i    (div_word_o),
        .tick_o (fb_tick_o)
    );
endmodule

// File: rtl/margin_divider_ctrl_chk.sv
// Module: assertion checker for margin_divider_ctrl, attached by bind.
// Assumes: it is connected to the internal synchronized enable and registers.
module margin_divider_ctrl_chk #(
    parameter int unsigned W       = 6,
    parameter int unsigned NOMINAL = 50,
    parameter int unsigned LO      = 45,
    parameter int unsigned HI      = 55
) (
    input logic         clk,
    input logic         rst_n,
    input logic         margin_mode_i,
    input logic [W-1:0] div_word_o,
    input logic         out_of_range_o,
    input logic         load_s,
    input logic         commit,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] ctrl_q
);
    assert_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !margin_mode_i |-> div_word_o == W'(NOMINAL));

    assert_margin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        margin_mode_i |-> div_word_o == ctrl_q);

    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> $stable(shift_q));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl_q));

    assert_inband_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_word_o >= W'(LO) && div_word_o <= W'(HI)) |-> !out_of_range_o);

    assert_outband_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_word_o < W'(LO) || div_word_o > W'(HI)) |-> out_of_range_o);
endmodule

bind margin_divider_ctrl margin_divider_ctrl_chk #(
    .W(W), .NOMINAL(NOMINAL), .LO(LO), .HI(HI)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .margin_mode_i  (margin_mode_i),
    .div_word_o     (div_word_o),
    .out_of_range_o (out_of_range_o),
    .load_s         (load_s),
    .commit         (commit),
    .shift_q        (shift_q),
    .ctrl_q         (ctrl_q)
);

// File: tb/margin_divider_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for margin_divider_ctrl, one task each.
module margin_divider_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0, sclk = 1'b0, sdata = 1'b0, mode = 1'b0;
    logic [5:0] word;
    logic       oor, tick;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    margin_divider_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .load_en_i(load_en), .sclk_i(sclk),
        .sdata_i(sdata), .margin_mode_i(mode), .div_word_o(word),
        .out_of_range_o(oor), .fb_tick_o(tick)
    );

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdata = b;   wait_n(3);
        sclk = 1'b1; wait_n(3);
        sclk = 1'b0; wait_n(3);
    endtask

    task automatic load_word(input logic [5:0] v);
        load_en = 1'b1; wait_n(4);
        for (int i = 5; i >= 0; i--) shift_bit(v[i]);
        load_en = 1'b0; wait_n(6);
    endtask

    task automatic measure_period(input string req, input int exp);
        int n;
        n = 0;
        while (!tick && n < 200) begin wait_n(1); n++; end
        wait_n(1); n = 0;
        while (!tick && n < 200) begin wait_n(1); n++; end
        wait_n(1); n = 1;
        while (!tick && n < 200) begin wait_n(1); n++; end
        check(req, n, exp);
    endtask

    task automatic t_reset();
        check("R1 word after reset", word, 50);
        check("R1 flag after reset", oor, 0);
        mode = 1'b1; wait_n(1);
        check("R1 committed ratio after reset", word, 50);
        check("R1 flag margin mode", oor, 0);
    endtask

    task automatic t_margin_load();
        mode = 1'b1;
        load_word(6'd45); check("R3 load 45", word, 45); check("R8 flag at 45", oor, 0);
        load_word(6'd55); check("R3 load 55", word, 55); check("R8 flag at 55", oor, 0);
        load_word(6'b100110); check("R3 msb-first 38", word, 38);
    endtask

    task automatic t_commit_on_fall();
        mode = 1'b1;
        load_word(6'd47);
        load_en = 1'b1; wait_n(4);
        for (int i = 5; i >= 0; i--) shift_bit(6'd53 >> i);
        wait_n(6);
        check("R5 unchanged while enable high", word, 47);
        load_en = 1'b0; wait_n(6);
        check("R5 committed on fall", word, 53);
    endtask

    task automatic t_ignore();
        mode = 1'b1;
        load_word(6'd49);
        for (int i = 0; i < 6; i++) shift_bit(i[0]);
        check("R4 word unchanged by idle clocks", word, 49);
        load_en = 1'b1; wait_n(6); load_en = 1'b0; wait_n(6);
        check("R4 shift register kept 49", word, 49);
    endtask

    task automatic t_nominal_load();
        mode = 1'b0;
        load_word(6'd52);
        check("R2 nominal ignores committed", word, 50);
        check("R2 flag nominal", oor, 0);
        mode = 1'b1; wait_n(1);
        check("R6 load in nominal mode visible", word, 52);
    endtask

    task automatic t_range_and_return();
        mode = 1'b1;
        load_word(6'd44); check("R8 word 44 unclamped", word, 44); check("R8 flag 44", oor, 1);
        load_word(6'd56); check("R8 word 56 unclamped", word, 56); check("R8 flag 56", oor, 1);
        load_word(6'd63); check("R8 flag 63", oor, 1);
        load_word(6'd0);  check("R8 word 0", word, 0); check("R8 flag 0", oor, 1);
        mode = 1'b0; wait_n(1);
        check("R7 back to nominal", word, 50); check("R7 flag cleared", oor, 0);
    endtask

    task automatic t_overlong();
        logic [7:0] bits;
        bits = 8'b1110_1101;
        mode = 1'b1;
        load_en = 1'b1; wait_n(4);
        for (int i = 7; i >= 0; i--) shift_bit(bits[i]);
        load_en = 1'b0; wait_n(6);
        check("R9 last six bits kept", word, 45);
    endtask

    task automatic t_tick();
        mode = 1'b0; wait_n(1);
        measure_period("R10 nominal period", 50);
        mode = 1'b1;
        load_word(6'd47);
        measure_period("R10 period 47", 47);
        load_word(6'd3);
        measure_period("R10 period 3", 3);
    endtask

    initial begin
        wait_n(3); rst_n = 1'b1; wait_n(2);
        t_reset();
        t_margin_load();
        t_commit_on_fall();
        t_ignore();
        t_nominal_load();
        t_range_and_return();
        t_overlong();
        t_tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_n(100000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule